// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Deadtime and Supply Lockout

This block sits between the filtered switch requests of one half-bridge and the two gate enables of that bridge. It turns each request into a gate enable only when the opposite switch has been off for a fixed number of clock cycles. It refuses to turn on either switch while both requests are asserted. It also applies the shutdown conditions of the driver. A delayed global enable, an overcurrent trip and the low-side supply state are combined into one kill that removes both gates. The high-side supply state removes only the high-side gate.

Each supply is monitored through two digital comparator flags: one for a fall below the lower threshold and one for a rise above the upper threshold. The block keeps a hysteresis state per supply, so a supply that has dropped out is trusted again only after it has crossed the upper threshold. A three-phase driver uses three instances. The global enable, the trip and the low-side supply flags are shared between them, and each phase has its own high-side supply flags.

Top module: `hb_interlock`

## Requirements
- R1: While reset is held, and directly after it, both gates are low. Both supplies are treated as not good, and the delayed enable is treated as low.
- R2: hs_gate and ls_gate are never high in the same cycle.
- R3: When hs_req and ls_req are both high, both gates are low in that same cycle.
- R4: A gate may be high only if the opposite gate was low for at least DEAD_CYC consecutive cycles before it, counting the cycle in which it went low. With the default DEAD_CYC=33, ls_gate falling in cycle t lets hs_gate rise in cycle t+33 at the earliest.
- R5: With no other condition blocking it, a gate follows its request in the same cycle. When its request drops, the gate goes low in that cycle.
- R6: drv_enable takes effect after EN_DLY_CYC clock edges (default 70). While the delayed enable is low, both gates are low.
- R7: While oc_trip is high, both gates are low in the same cycle.
- R8: Low-side supply state: a cycle with ls_sup_low=1 marks the supply bad from the next cycle. A cycle with ls_sup_high=1 and ls_sup_low=0 marks it good from the next cycle. If both flags are 0, the state holds, and the low flag wins when both are set. A bad low-side supply forces both gates low.
- R9: The high-side supply has the same hysteresis on hs_sup_low and hs_sup_high. A bad high-side supply forces hs_gate low and does not affect ls_gate.
- R10: When any shutdown is released, a gate turns on again only if the deadtime rule of R4 holds. Cycles spent in shutdown with both gates low count toward that deadtime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_req | input | 1 | Filtered high-side on request |
| ls_req | input | 1 | Filtered low-side on request |
| drv_enable | input | 1 | Global drive enable, delayed internally |
| oc_trip | input | 1 | Latched overcurrent condition |
| ls_sup_low | input | 1 | Low-side supply below lower threshold |
| ls_sup_high | input | 1 | Low-side supply above upper threshold |
| hs_sup_low | input | 1 | High-side supply below lower threshold |
| hs_sup_high | input | 1 | High-side supply above upper threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The deadtime countdown and a shutdown can fall in the same cycle. One case is an overcurrent trip or supply dropout while a gate is on and the other side is waiting. Another is a release of the kill in the same cycle that the deadtime count of the opposite side expires. The bench provokes both. It holds a request on through a trip or supply pulse, and it releases the enable so that the delayed enable arrives during and after a pending deadtime. A behavioural model with its own cycle counters judges every clock. It requires the gate to stay low until both the release and the full off-gap are satisfied.

// File: rtl/hb_pkg.sv
// Shared definitions for the half-bridge interlock.
// Assumes: counters saturate at their limit, so width only needs limit+1 codes.
package hb_pkg;

    typedef enum logic {
        SUP_BAD  = 1'b0,
        SUP_GOOD = 1'b1
    } sup_state_t;

    localparam int SIDE_HS = 0;
    localparam int SIDE_LS = 1;

    // Bits needed to hold the values 0..limit.
    function automatic int cnt_bits(input int limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/hb_sup_hyst.sv
// Two-threshold supply monitor. Turns a "below lower" and an "above upper"
// comparator flag into a held good/bad state.
// Assumes: flags are already synchronous to clk; low flag has priority.
module hb_sup_hyst
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below_lo,
    input  logic above_hi,
    output logic good
);

    sup_state_t state_q;

    // Hysteresis state: drop on low flag, recover only on high flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SUP_BAD;
        end else if (below_lo) begin
            state_q <= SUP_BAD;
        end else if (above_hi) begin
            state_q <= SUP_GOOD;
        end
    end

    assign good = (state_q == SUP_GOOD);

endmodule

// File: rtl/hb_off_timer.sv
// Counts consecutive cycles a gate has been low and flags when the off-gap
// reaches the deadtime. The cycle the gate goes low is the first one counted.
// Assumes: reset state means the gate has been off long enough.
module hb_off_timer
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    output logic gap_done
);

    localparam int CW = cnt_bits(DEAD_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC);

    logic [CW-1:0] low_run_q;

    // Saturating run-length of low cycles, cleared while the gate is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= LIMIT;
        end else if (gate_on) begin
            low_run_q <= '0;
        end else if (low_run_q != LIMIT) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    assign gap_done = (low_run_q == LIMIT);

endmodule

// File: rtl/hb_en_delay.sv
// Fixed-latency delay of the global enable.
// Assumes: the delay is short enough for a shift register; reset reads as disabled.
module hb_en_delay #(
    parameter int DLY_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_out
);

    generate
        if (DLY_CYC == 0) begin : g_bypass
            assign en_out = en_in;
        end else begin : g_pipe
            logic [DLY_CYC-1:0] pipe_q;

            // Shift the enable through DLY_CYC stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else if (DLY_CYC == 1) begin
                    pipe_q[0] <= en_in;
                end else begin
                    pipe_q <= {pipe_q[DLY_CYC-2:0], en_in};
                end
            end

            assign en_out = pipe_q[DLY_CYC-1];
        end
    endgenerate

endmodule

// File: rtl/hb_interlock.sv
// One half-bridge gate interlock. Produces the two gate enables from the
// requests. It enforces mutual exclusion and a deadtime, and it applies the
// global kill (delayed enable, trip, low-side supply) and the high-side
// supply lockout.
// Assumes: requests are already noise filtered; turn-off paths are
// combinational so a kill acts in its own cycle.
module hb_interlock
    import hb_pkg::*;
#(
    parameter int DEAD_CYC   = 33,
    parameter int EN_DLY_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    input  logic ls_req,
    input  logic drv_enable,
    input  logic oc_trip,
    input  logic ls_sup_low,
    input  logic ls_sup_high,
    input  logic hs_sup_low,
    input  logic hs_sup_high,
    output logic hs_gate,
    output logic ls_gate
);

    localparam int NSIDE = 2;

    logic en_eff;
    logic ls_good;
    logic hs_good;
    logic kill_all;
    logic hs_want;
    logic ls_want;
    logic [NSIDE-1:0] gate_vec;
    logic [NSIDE-1:0] gap_vec;

    hb_en_delay #(.DLY_CYC(EN_DLY_CYC)) u_en_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (drv_enable),
        .en_out (en_eff)
    );

    hb_sup_hyst u_ls_sup (
        .clk      (clk),
        .rst_n    (rst_n),
        .below_lo (ls_sup_low),
        .above_hi (ls_sup_high),
        .good     (ls_good)
    );

    hb_sup_hyst u_hs_sup (
        .clk      (clk),
        .rst_n    (rst_n),
        .below_lo (hs_sup_low),
        .above_hi (hs_sup_high),
        .good     (hs_good)
    );

    assign gate_vec[SIDE_HS] = hs_gate;
    assign gate_vec[SIDE_LS] = ls_gate;

    // One off-gap timer per side; gap_vec[k] says side k has been off long enough.
    generate
        for (genvar k = 0; k < NSIDE; k++) begin : g_side
            hb_off_timer #(.DEAD_CYC(DEAD_CYC)) u_gap (
                .clk      (clk),
                .rst_n    (rst_n),
                .gate_on  (gate_vec[k]),
                .gap_done (gap_vec[k])
            );
        end
    endgenerate

    // Kill and request qualification; both requests together cancel each other.
    always_comb begin
        kill_all = !en_eff || oc_trip || !ls_good;
        hs_want  = hs_req && !ls_req;
        ls_want  = ls_req && !hs_req;
    end

    // Final gates: request, no kill, and the opposite side's gap complete.
    assign hs_gate = hs_want && !kill_all && hs_good && gap_vec[SIDE_LS];
    assign ls_gate = ls_want && !kill_all && gap_vec[SIDE_HS];

endmodule

// File: rtl/hb_interlock_chk.sv
// Property checker for hb_interlock, bound to every instance.
// Assumes: same DEAD_CYC as the checked instance.
module hb_interlock_chk #(
    parameter int DEAD_CYC = 33
) (
    input logic clk,
    input logic rst_n,
    input logic hs_req,
    input logic ls_req,
    input logic oc_trip,
    input logic ls_sup_low,
    input logic hs_sup_low,
    input logic hs_gate,
    input logic ls_gate
);

    int hs_off_run;
    int ls_off_run;

    // Independent run-length of low cycles per gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_off_run <= DEAD_CYC;
            ls_off_run <= DEAD_CYC;
        end else begin
            hs_off_run <= hs_gate ? 0 : ((hs_off_run >= DEAD_CYC) ? DEAD_CYC : hs_off_run + 1);
            ls_off_run <= ls_gate ? 0 : ((ls_off_run >= DEAD_CYC) ? DEAD_CYC : ls_off_run + 1);
        end
    end

    p_never_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    p_both_req_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req && ls_req) |-> (!hs_gate && !ls_gate));

    p_hs_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> (ls_off_run >= DEAD_CYC));

    p_ls_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> (hs_off_run >= DEAD_CYC));

    p_trip_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> (!hs_gate && !ls_gate));

    p_ls_uv_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ls_sup_low |=> (!hs_gate && !ls_gate));

    p_hs_uv_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_sup_low |=> !hs_gate);

endmodule

bind hb_interlock hb_interlock_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_req     (hs_req),
    .ls_req     (ls_req),
    .oc_trip    (oc_trip),
    .ls_sup_low (ls_sup_low),
    .hs_sup_low (hs_sup_low),
    .hs_gate    (hs_gate),
    .ls_gate    (ls_gate)
);

// File: tb/sim_hb_interlock.sv
// Bench for hb_interlock: behavioural reference model compared every cycle.
module sim_hb_interlock;

    localparam int DEAD = 33;
    localparam int EDLY = 70;
    localparam int WATCHDOG = 60000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_req = 0, ls_req = 0, drv_enable = 0, oc_trip = 0;
    logic ls_sup_low = 0, ls_sup_high = 0, hs_sup_low = 0, hs_sup_high = 0;
    logic hs_gate, ls_gate;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R1";

    // Reference model state.
    bit en_q[$];
    bit m_ls_ok, m_hs_ok;
    int m_hs_off, m_ls_off;

    always #2 clk = ~clk;

    hb_interlock #(.DEAD_CYC(DEAD), .EN_DLY_CYC(EDLY)) u0 (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
        .drv_enable(drv_enable), .oc_trip(oc_trip),
        .ls_sup_low(ls_sup_low), .ls_sup_high(ls_sup_high),
        .hs_sup_low(hs_sup_low), .hs_sup_high(hs_sup_high),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    task automatic model_reset();
        en_q.delete();
        for (int i = 0; i < EDLY; i++) en_q.push_back(1'b0);
        m_ls_ok = 0;
        m_hs_ok = 0;
        m_hs_off = DEAD;
        m_ls_off = DEAD;
    endtask

    task automatic check(input string t, input logic act, input logic exp, input string nm);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b cycle=%0d", t, nm, act, exp, cyc);
        end
    endtask

    // One cycle: settle, compare against model, advance model, go to next negedge.
    task automatic tick();
        bit en_eff, kill, e_hs, e_ls;
        #1;
        en_eff = (EDLY == 0) ? drv_enable : en_q[0];
        kill = !en_eff || oc_trip || !m_ls_ok;
        e_hs = hs_req && !ls_req && !kill && m_hs_ok && (m_ls_off >= DEAD);
        e_ls = ls_req && !hs_req && !kill && (m_hs_off >= DEAD);
        check(tag, hs_gate, e_hs, "hs_gate");
        check(tag, ls_gate, e_ls, "ls_gate");
        if (hs_gate === 1'b1 && ls_gate === 1'b1) check("R2", 1'b1, 1'b0, "both_high");
        if (!rst_n) begin
            model_reset();
        end else begin
            en_q.push_back(drv_enable);
            void'(en_q.pop_front());
            if (ls_sup_low) m_ls_ok = 0; else if (ls_sup_high) m_ls_ok = 1;
            if (hs_sup_low) m_hs_ok = 0; else if (hs_sup_high) m_hs_ok = 1;
            m_hs_off = e_hs ? 0 : ((m_hs_off >= DEAD) ? DEAD : m_hs_off + 1);
            m_ls_off = e_ls ? 0 : ((m_ls_off >= DEAD) ? DEAD : m_ls_off + 1);
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        // R1: reset state, even with requests and supplies asserted.
        tag = "R1";
        hs_req = 1; ls_sup_high = 1; hs_sup_high = 1; drv_enable = 1;
        run(4);
        rst_n = 1;
        hs_req = 0; ls_sup_high = 0; hs_sup_high = 0;
        run(2);
        // R8/R9: supplies come up through the upper flags, then hold.
        tag = "R8";
        ls_sup_high = 1; hs_sup_high = 1; run(1);
        ls_sup_high = 0; hs_sup_high = 0;
        // R6: requests ignored until the delayed enable arrives.
        tag = "R6";
        hs_req = 1; run(EDLY + 4);
        // R5: gate follows request, turn-off in the same cycle.
        tag = "R5";
        hs_req = 0; run(2); hs_req = 1; run(5); hs_req = 0; run(1);
        // R4: low side waits for the gap, then high side waits in turn.
        tag = "R4";
        ls_req = 1; run(DEAD + 5);
        ls_req = 0; hs_req = 1; run(DEAD + 5);
        // R3: both requests cancel; then one drops and the gap still applies.
        tag = "R3";
        ls_req = 1; run(6);
        hs_req = 0; run(DEAD + 3);
        ls_req = 0; run(2);
        // R7: trip kills the active gate in its own cycle.
        tag = "R7";
        hs_req = 1; run(DEAD + 2);
        oc_trip = 1; run(3); oc_trip = 0; run(3);
        // R10: trip released while the opposite side is still within its gap.
        tag = "R10";
        hs_req = 0; ls_req = 1; oc_trip = 1; run(10);
        oc_trip = 0; run(DEAD);
        ls_req = 0; run(2);
        // R8: low-side dropout kills both; middle band holds bad; upper recovers.
        tag = "R8";
        ls_req = 1; run(DEAD + 2);
        ls_sup_low = 1; run(1); ls_sup_low = 0; run(5);
        ls_sup_low = 1; ls_sup_high = 1; run(1);
        ls_sup_low = 0; run(1); ls_sup_high = 0; run(DEAD + 3);
        // R9: high-side dropout affects only the high side.
        tag = "R9";
        hs_sup_low = 1; run(1); hs_sup_low = 0; run(3);
        ls_req = 0; hs_req = 1; run(DEAD + 4);
        ls_req = 1; hs_req = 0; run(DEAD + 4);
        hs_sup_high = 1; run(1); hs_sup_high = 0;
        ls_req = 0; hs_req = 1; run(DEAD + 4);
        // R6/R10: enable drops and returns; turn-on waits for delay and gap.
        tag = "R6";
        drv_enable = 0; run(EDLY + 3);
        hs_req = 0; ls_req = 1;
        drv_enable = 1; tag = "R10"; run(EDLY + DEAD + 4);
        drv_enable = 0; run(EDLY - 10); ls_req = 0; hs_req = 1; run(20);
        drv_enable = 1; run(EDLY + 5);
        // R2: random mix of all inputs.
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom;
            if (r[3:0] == 0) hs_req = ~hs_req;
            if (r[7:4] == 0) ls_req = ~ls_req;
            oc_trip     = (r[15:10] == 0);
            ls_sup_low  = (r[23:17] == 0);
            ls_sup_high = (r[26:24] == 0);
            hs_sup_low  = (r[31:27] == 0);
            hs_sup_high = r[16];
            if (r[9:8] == 0 && r[5:4] == 0) drv_enable = ~drv_enable;
            tick();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule